// File: doc/BRIEF.md
# Banked Vector Base Register Unit

This unit holds the exception vector base configuration for a core that runs in either a secure or a non-secure state. It decodes system-register accesses that name a register by four fields: a primary register number, opcode-1, a secondary register number and opcode-2. Within the primary group 12 it provides three registers. The vector base register has one copy per security state. The monitor vector base register has a single copy. The interrupt status register is read-only and reflects the pending interrupt lines. The unit also drives, every cycle, the exception base address that the core uses when it takes an exception.

An access is presented for one cycle on the access inputs. The unit classifies it and commits any write at the next rising edge. It reports the result in the following cycle on the response outputs. The response path is a four-state machine, and its state is the kind of response being returned. RSP_NONE means no access to group 12 was seen. RSP_DATA means the access was accepted. RSP_UNDEF means an undefined-instruction indication. RSP_UNPRED means the encoding is unallocated and the access was treated as a no-op. From any state the machine moves at every edge to the state that matches the access seen in that cycle. An idle cycle, or an access outside group 12, leads to RSP_NONE. A legal, permitted access leads to RSP_DATA. A privilege or security violation, or any access when security support is absent, leads to RSP_UNDEF. An unallocated encoding in group 12 leads to RSP_UNPRED. Reset puts the machine in RSP_NONE.

Top module: `vecbase_regs`

## Requirements
- R1: With primary register 12 and opcode-1 0, secondary 0 with opcode-2 0 selects the vector base register, secondary 0 with opcode-2 1 selects the monitor vector base register, and secondary 1 with opcode-2 0 selects the interrupt status register. The response to an access appears in the cycle after it is presented. An accepted access raises only rsp_valid. Its rsp_rdata carries the register value on a read and 0 on a write.
- R2: Any other encoding with primary register 12 gives rsp_valid and rsp_unpred and changes no register. An access with any other primary register gives no response.
- R3: An access to any of the three registers while priv_mode is low gives rsp_valid and rsp_undef and changes no register.
- R4: The vector base register is banked. sec_state high reads and writes the secure copy, and sec_state low reads and writes the non-secure copy.
- R5: Reset clears the secure copy to 0. The non-secure copy and the monitor vector base register are not reset.
- R6: While sec_wlock is high, a write to the secure copy is accepted but leaves it unchanged. Reads still return its value, and writes to the non-secure copy still take effect.
- R7: While hivec_sel is high, exc_base is 0xFFFF0000 in either security state.
- R8: While hivec_sel is low, exc_base equals the vector base copy for the current sec_state.
- R9: Bits [4:0] of both vector base registers read as 0 whatever was written.
- R10: The interrupt status register reads pend_abort in bit 8, pend_irq in bit 7 and pend_fiq in bit 6, with all other bits 0, sampled in the access cycle. A write to it is accepted and has no effect.
- R11: The monitor vector base register has a single copy. An access to it with sec_state low gives rsp_undef and changes nothing. sec_wlock blocks writes to it.
- R12: A write takes effect at the edge that ends its access cycle. A read in the very next cycle, and exc_base in that cycle, show the new value.
- R13: With HAS_SECURITY set to 0, every access with primary register 12 gives rsp_undef.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_crn | input | 4 | Primary register number |
| acc_op1 | input | 3 | Opcode-1 field |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Opcode-2 field |
| acc_wdata | input | 32 | Write data |
| sec_state | input | 1 | 1 = secure state |
| priv_mode | input | 1 | 1 = privileged mode |
| hivec_sel | input | 1 | High exception vectors selected |
| sec_wlock | input | 1 | Blocks writes to secure-only registers |
| pend_abort | input | 1 | Pending external abort |
| pend_irq | input | 1 | Pending normal interrupt |
| pend_fiq | input | 1 | Pending fast interrupt |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data |
| rsp_undef | output | 1 | Undefined-instruction indication |
| rsp_unpred | output | 1 | Unallocated encoding, treated as no-op |
| exc_base | output | 32 | Exception base address |

## Verification
Several rules are checked by assertions on every cycle. A locked write leaves the secure copy and the monitor register unchanged. A cycle with no write request leaves all three registers untouched. An unlocked secure write lands its upper bits in the next cycle. An unprivileged hit to a decoded register always leads to the undefined response, and a cycle with no group-12 access always leads to no response. Other behaviours show only through the bench's scenarios. These are the value each bank copy returns as the security state changes, the alignment masking, the interrupt line packing, the high-vector override of exc_base, the read-after-write in the very next cycle, and the all-undefined variant with security support removed.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

    localparam logic [3:0] GRP_CRN   = 4'd12;
    localparam logic [31:0] HIVEC_BASE = 32'hFFFF_0000;

    localparam int ISR_ABORT_BIT = 8;
    localparam int ISR_IRQ_BIT   = 7;
    localparam int ISR_FIQ_BIT   = 6;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_DATA   = 2'd1,
        RSP_UNDEF  = 2'd2,
        RSP_UNPRED = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_VBASE = 2'd1,
        SEL_MBASE = 2'd2,
        SEL_ISTAT = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/vbr_decode.sv
module vbr_decode
    import vbr_pkg::*;
#(
    parameter bit HAS_SECURITY = 1'b1
) (
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic [3:0] acc_crn,
    input  logic [2:0] acc_op1,
    input  logic [3:0] acc_crm,
    input  logic [2:0] acc_op2,
    input  logic       sec_state,
    input  logic       priv_mode,
    output logic       grp_hit,
    output reg_sel_e   sel,
    output rsp_kind_e  kind,
    output logic       wr_sec,
    output logic       wr_nsec,
    output logic       wr_mon
);

    logic enc_base;

    always_comb begin
        grp_hit  = acc_valid && (acc_crn == GRP_CRN);
        enc_base = (acc_op1 == 3'd0);
        sel      = SEL_NONE;
        kind     = RSP_NONE;
        wr_sec   = 1'b0;
        wr_nsec  = 1'b0;
        wr_mon   = 1'b0;
        if (grp_hit) begin
            if (!HAS_SECURITY) begin
                kind = RSP_UNDEF;
            end else begin
                if (enc_base && acc_crm == 4'd0 && acc_op2 == 3'd0)
                    sel = SEL_VBASE;
                else if (enc_base && acc_crm == 4'd0 && acc_op2 == 3'd1)
                    sel = SEL_MBASE;
                else if (enc_base && acc_crm == 4'd1 && acc_op2 == 3'd0)
                    sel = SEL_ISTAT;

                if (sel == SEL_NONE) begin
                    kind = RSP_UNPRED;
                end else if (!priv_mode || (sel == SEL_MBASE && !sec_state)) begin
                    kind = RSP_UNDEF;
                end else begin
                    kind = RSP_DATA;
                    if (acc_write) begin
                        wr_sec  = (sel == SEL_VBASE) &&  sec_state;
                        wr_nsec = (sel == SEL_VBASE) && !sec_state;
                        wr_mon  = (sel == SEL_MBASE);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/vbr_bank.sv
module vbr_bank #(
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_sec,
    input  logic                       wr_nsec,
    input  logic                       wr_mon,
    input  logic                       wlock,
    input  logic [DATA_W-1:ALIGN_BITS] wdata_hi,
    output logic [DATA_W-1:0]          vbase_sec,
    output logic [DATA_W-1:0]          vbase_nsec,
    output logic [DATA_W-1:0]          mbase
);

    localparam int HI_W = DATA_W - ALIGN_BITS;

    logic [HI_W-1:0] sec_q;
    logic [HI_W-1:0] nsec_q;
    logic [HI_W-1:0] mon_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_q <= '0;
        else if (wr_sec && !wlock)
            sec_q <= wdata_hi;
    end

    always_ff @(posedge clk) begin
        if (wr_nsec)
            nsec_q <= wdata_hi;
    end

    always_ff @(posedge clk) begin
        if (wr_mon && !wlock)
            mon_q <= wdata_hi;
    end

    assign vbase_sec  = {sec_q,  {ALIGN_BITS{1'b0}}};
    assign vbase_nsec = {nsec_q, {ALIGN_BITS{1'b0}}};
    assign mbase      = {mon_q,  {ALIGN_BITS{1'b0}}};

    // R6
    sec_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sec && wlock) |=> $stable(sec_q));

    // R11
    mon_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mon && wlock) |=> $stable(mon_q));

    // R3
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_sec || wr_nsec || wr_mon) |=> ($stable(sec_q) && $stable(nsec_q) && $stable(mon_q)));

    // R12
    sec_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sec && !wlock) |=> (sec_q == $past(wdata_hi)));

endmodule

// File: rtl/vbr_rsp_fsm.sv
module vbr_rsp_fsm
    import vbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rsp_kind_e         nxt_kind,
    input  logic [DATA_W-1:0] nxt_rdata,
    input  logic              grp_hit,
    input  reg_sel_e          sel,
    input  logic              priv_mode,
    output logic              rsp_valid,
    output logic              rsp_undef,
    output logic              rsp_unpred,
    output logic [DATA_W-1:0] rsp_rdata
);

    rsp_kind_e         state_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_NONE;
            rdata_q <= '0;
        end else begin
            state_q <= nxt_kind;
            rdata_q <= (nxt_kind == RSP_DATA) ? nxt_rdata : '0;
        end
    end

    always_comb begin
        rsp_valid  = 1'b0;
        rsp_undef  = 1'b0;
        rsp_unpred = 1'b0;
        unique case (state_q)
            RSP_NONE:   ;
            RSP_DATA:   rsp_valid = 1'b1;
            RSP_UNDEF:  begin rsp_valid = 1'b1; rsp_undef  = 1'b1; end
            RSP_UNPRED: begin rsp_valid = 1'b1; rsp_unpred = 1'b1; end
            default:    ;
        endcase
    end

    assign rsp_rdata = rdata_q;

    // R3
    unpriv_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel != SEL_NONE) && !priv_mode) |=> rsp_undef);

    // R2
    outside_group_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_hit |=> !rsp_valid);

endmodule

// File: rtl/vecbase_regs.sv
module vecbase_regs
    import vbr_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ALIGN_BITS   = 5,
    parameter bit HAS_SECURITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [3:0]        acc_crn,
    input  logic [2:0]        acc_op1,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_op2,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              sec_state,
    input  logic              priv_mode,
    input  logic              hivec_sel,
    input  logic              sec_wlock,
    input  logic              pend_abort,
    input  logic              pend_irq,
    input  logic              pend_fiq,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_undef,
    output logic              rsp_unpred,
    output logic [DATA_W-1:0] exc_base
);

    logic              grp_hit;
    reg_sel_e          sel;
    rsp_kind_e         kind;
    logic              wr_sec, wr_nsec, wr_mon;
    logic [DATA_W-1:0] vbase_sec, vbase_nsec, mbase;
    logic [DATA_W-1:0] istat, rd_mux;
    logic              unused_low_wdata;

    assign unused_low_wdata = ^acc_wdata[ALIGN_BITS-1:0];

    vbr_decode #(.HAS_SECURITY(HAS_SECURITY)) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_crn   (acc_crn),
        .acc_op1   (acc_op1),
        .acc_crm   (acc_crm),
        .acc_op2   (acc_op2),
        .sec_state (sec_state),
        .priv_mode (priv_mode),
        .grp_hit   (grp_hit),
        .sel       (sel),
        .kind      (kind),
        .wr_sec    (wr_sec),
        .wr_nsec   (wr_nsec),
        .wr_mon    (wr_mon)
    );

    vbr_bank #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sec     (wr_sec),
        .wr_nsec    (wr_nsec),
        .wr_mon     (wr_mon),
        .wlock      (sec_wlock),
        .wdata_hi   (acc_wdata[DATA_W-1:ALIGN_BITS]),
        .vbase_sec  (vbase_sec),
        .vbase_nsec (vbase_nsec),
        .mbase      (mbase)
    );

    always_comb begin
        istat = '0;
        istat[ISR_ABORT_BIT] = pend_abort;
        istat[ISR_IRQ_BIT]   = pend_irq;
        istat[ISR_FIQ_BIT]   = pend_fiq;
        rd_mux = '0;
        if (!acc_write) begin
            unique case (sel)
                SEL_VBASE: rd_mux = sec_state ? vbase_sec : vbase_nsec;
                SEL_MBASE: rd_mux = mbase;
                SEL_ISTAT: rd_mux = istat;
                default:   rd_mux = '0;
            endcase
        end
    end

    vbr_rsp_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_kind   (kind),
        .nxt_rdata  (rd_mux),
        .grp_hit    (grp_hit),
        .sel        (sel),
        .priv_mode  (priv_mode),
        .rsp_valid  (rsp_valid),
        .rsp_undef  (rsp_undef),
        .rsp_unpred (rsp_unpred),
        .rsp_rdata  (rsp_rdata)
    );

    generate
        if (HAS_SECURITY) begin : g_banked
            assign exc_base = hivec_sel ? HIVEC_BASE[DATA_W-1:0]
                                        : (sec_state ? vbase_sec : vbase_nsec);
        end else begin : g_flat
            assign exc_base = hivec_sel ? HIVEC_BASE[DATA_W-1:0] : '0;
        end
    endgenerate

endmodule

// File: tb/sim_vecbase_regs.sv
module sim_vecbase_regs;

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic        pv;
        logic [3:0]  crn;
        logic [2:0]  op1;
        logic [3:0]  crm;
        logic [2:0]  op2;
        logic [31:0] wd;
        logic [1:0]  kind;   // 0 none, 1 data, 2 undef, 3 unpred
        logic [31:0] rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b1,1'b1,4'd12,3'd0,4'd0,3'd0,32'h0,        2'd1,32'h0,        4'd5},  // R5 secure copy reset
        '{1'b1,1'b1,1'b1,4'd12,3'd0,4'd0,3'd0,32'h1234_567F,2'd1,32'h0,        4'd1},  // R1 write
        '{1'b0,1'b1,1'b1,4'd12,3'd0,4'd0,3'd0,32'h0,        2'd1,32'h1234_5660,4'd9},  // R9 R12
        '{1'b1,1'b0,1'b1,4'd12,3'd0,4'd0,3'd0,32'h8000_0020,2'd1,32'h0,        4'd4},  // R4
        '{1'b0,1'b0,1'b1,4'd12,3'd0,4'd0,3'd0,32'h0,        2'd1,32'h8000_0020,4'd4},  // R4
        '{1'b0,1'b1,1'b1,4'd12,3'd0,4'd0,3'd0,32'h0,        2'd1,32'h1234_5660,4'd4},  // R4
        '{1'b1,1'b1,1'b1,4'd12,3'd0,4'd0,3'd1,32'hCAFE_0000,2'd1,32'h0,        4'd1},  // R1 monitor
        '{1'b0,1'b1,1'b1,4'd12,3'd0,4'd0,3'd1,32'h0,        2'd1,32'hCAFE_0000,4'd11}, // R11
        '{1'b0,1'b0,1'b1,4'd12,3'd0,4'd0,3'd1,32'h0,        2'd2,32'h0,        4'd11}, // R11
        '{1'b1,1'b0,1'b1,4'd12,3'd0,4'd0,3'd1,32'h1111_1100,2'd2,32'h0,        4'd11}, // R11
        '{1'b0,1'b1,1'b1,4'd12,3'd0,4'd0,3'd1,32'h0,        2'd1,32'hCAFE_0000,4'd11}, // R11
        '{1'b0,1'b1,1'b0,4'd12,3'd0,4'd0,3'd0,32'h0,        2'd2,32'h0,        4'd3},  // R3
        '{1'b1,1'b1,1'b0,4'd12,3'd0,4'd0,3'd0,32'hFFFF_FFFF,2'd2,32'h0,        4'd3},  // R3
        '{1'b0,1'b1,1'b1,4'd12,3'd0,4'd0,3'd0,32'h0,        2'd1,32'h1234_5660,4'd3},  // R3
        '{1'b1,1'b1,1'b1,4'd12,3'd0,4'd0,3'd2,32'hFFFF_FFFF,2'd3,32'h0,        4'd2},  // R2
        '{1'b0,1'b1,1'b1,4'd12,3'd0,4'd1,3'd1,32'h0,        2'd3,32'h0,        4'd2},  // R2
        '{1'b1,1'b1,1'b1,4'd12,3'd1,4'd0,3'd0,32'hFFFF_FFFF,2'd3,32'h0,        4'd2},  // R2
        '{1'b0,1'b1,1'b1,4'd12,3'd0,4'd0,3'd0,32'h0,        2'd1,32'h1234_5660,4'd2},  // R2
        '{1'b1,1'b1,1'b1,4'd13,3'd0,4'd0,3'd0,32'hFFFF_FFFF,2'd0,32'h0,        4'd2}   // R2
    };

    logic clk = 1'b0;
    logic rst_n;
    logic acc_valid, acc_write;
    logic [3:0] acc_crn, acc_crm;
    logic [2:0] acc_op1, acc_op2;
    logic [31:0] acc_wdata;
    logic sec_state, priv_mode, hivec_sel, sec_wlock;
    logic pend_abort, pend_irq, pend_fiq;
    logic rsp_valid, rsp_undef, rsp_unpred;
    logic [31:0] rsp_rdata, exc_base;
    logic f_valid, f_undef, f_unpred;
    logic [31:0] f_rdata, f_base;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    vecbase_regs u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_crn(acc_crn), .acc_op1(acc_op1), .acc_crm(acc_crm), .acc_op2(acc_op2),
        .acc_wdata(acc_wdata), .sec_state(sec_state), .priv_mode(priv_mode),
        .hivec_sel(hivec_sel), .sec_wlock(sec_wlock), .pend_abort(pend_abort),
        .pend_irq(pend_irq), .pend_fiq(pend_fiq), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef), .rsp_unpred(rsp_unpred),
        .exc_base(exc_base)
    );

    vecbase_regs #(.HAS_SECURITY(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_crn(acc_crn), .acc_op1(acc_op1), .acc_crm(acc_crm), .acc_op2(acc_op2),
        .acc_wdata(acc_wdata), .sec_state(sec_state), .priv_mode(priv_mode),
        .hivec_sel(hivec_sel), .sec_wlock(sec_wlock), .pend_abort(pend_abort),
        .pend_irq(pend_irq), .pend_fiq(pend_fiq), .rsp_valid(f_valid),
        .rsp_rdata(f_rdata), .rsp_undef(f_undef), .rsp_unpred(f_unpred),
        .exc_base(f_base)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with the response visible.
    task automatic access(input logic wr, input logic sec, input logic pv,
                          input logic [3:0] crn, input logic [2:0] op1,
                          input logic [3:0] crm, input logic [2:0] op2,
                          input logic [31:0] wd);
        acc_valid = 1'b1; acc_write = wr; sec_state = sec; priv_mode = pv;
        acc_crn = crn; acc_op1 = op1; acc_crm = crm; acc_op2 = op2; acc_wdata = wd;
        @(negedge clk);
    endtask

    task automatic idle();
        acc_valid = 1'b0; acc_write = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_rsp(input logic [1:0] kind, input logic [31:0] rd, input string req);
        logic [2:0] act_f, exp_f;
        act_f = {rsp_valid, rsp_undef, rsp_unpred};
        exp_f = {kind != 2'd0, kind == 2'd2, kind == 2'd3};
        check(act_f == exp_f, req, "response flags", {29'd0, act_f}, {29'd0, exp_f});
        check(rsp_rdata == rd, req, "read data", rsp_rdata, rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
        acc_crn = 4'd0; acc_op1 = 3'd0; acc_crm = 4'd0; acc_op2 = 3'd0; acc_wdata = 32'd0;
        sec_state = 1'b1; priv_mode = 1'b1; hivec_sel = 1'b0; sec_wlock = 1'b0;
        pend_abort = 1'b0; pend_irq = 1'b0; pend_fiq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset state
        check(!rsp_valid && !rsp_undef && !rsp_unpred, "R5", "idle after reset",
              {29'd0, rsp_valid, rsp_undef, rsp_unpred}, 32'd0);
        check(exc_base == 32'h0, "R5", "secure base after reset", exc_base, 32'h0);

        // vector table walk, back-to-back accesses
        for (int i = 0; i < NV; i++) begin
            access(VT[i].wr, VT[i].sec, VT[i].pv, VT[i].crn, VT[i].op1,
                   VT[i].crm, VT[i].op2, VT[i].wd);
            check_rsp(VT[i].kind, VT[i].rd, $sformatf("R%0d", VT[i].req));
        end
        idle();

        // R8 exception base follows the current bank
        sec_state = 1'b1; #1;
        check(exc_base == 32'h1234_5660, "R8", "secure base", exc_base, 32'h1234_5660);
        sec_state = 1'b0; #1;
        check(exc_base == 32'h8000_0020, "R8", "non-secure base", exc_base, 32'h8000_0020);
        // R7 high vectors override
        hivec_sel = 1'b1; #1;
        check(exc_base == 32'hFFFF_0000, "R7", "high vectors non-secure", exc_base, 32'hFFFF_0000);
        sec_state = 1'b1; #1;
        check(exc_base == 32'hFFFF_0000, "R7", "high vectors secure", exc_base, 32'hFFFF_0000);
        hivec_sel = 1'b0;
        @(negedge clk);

        // R10 interrupt status packing and write ignore
        pend_abort = 1'b1; pend_irq = 1'b0; pend_fiq = 1'b1;
        access(1'b0, 1'b1, 1'b1, 4'd12, 3'd0, 4'd1, 3'd0, 32'h0);
        check_rsp(2'd1, 32'h0000_0140, "R10");
        pend_abort = 1'b0; pend_irq = 1'b1; pend_fiq = 1'b0;
        access(1'b0, 1'b1, 1'b1, 4'd12, 3'd0, 4'd1, 3'd0, 32'h0);
        check_rsp(2'd1, 32'h0000_0080, "R10");
        pend_irq = 1'b0;
        access(1'b1, 1'b1, 1'b1, 4'd12, 3'd0, 4'd1, 3'd0, 32'hFFFF_FFFF);
        check_rsp(2'd1, 32'h0, "R10");
        access(1'b0, 1'b1, 1'b1, 4'd12, 3'd0, 4'd1, 3'd0, 32'h0);
        check_rsp(2'd1, 32'h0, "R10");

        // R6 secure write lock
        sec_wlock = 1'b1;
        access(1'b1, 1'b1, 1'b1, 4'd12, 3'd0, 4'd0, 3'd0, 32'hAAAA_0000);
        check_rsp(2'd1, 32'h0, "R6");
        access(1'b0, 1'b1, 1'b1, 4'd12, 3'd0, 4'd0, 3'd0, 32'h0);
        check_rsp(2'd1, 32'h1234_5660, "R6");
        access(1'b1, 1'b0, 1'b1, 4'd12, 3'd0, 4'd0, 3'd0, 32'h0BAD_0040);
        access(1'b0, 1'b0, 1'b1, 4'd12, 3'd0, 4'd0, 3'd0, 32'h0);
        check_rsp(2'd1, 32'h0BAD_0040, "R6");
        // R11 lock covers the monitor base
        access(1'b1, 1'b1, 1'b1, 4'd12, 3'd0, 4'd0, 3'd1, 32'h5555_5540);
        access(1'b0, 1'b1, 1'b1, 4'd12, 3'd0, 4'd0, 3'd1, 32'h0);
        check_rsp(2'd1, 32'hCAFE_0000, "R11");
        sec_wlock = 1'b0;

        // R12 write then read in the next cycle, base follows at once
        access(1'b1, 1'b1, 1'b1, 4'd12, 3'd0, 4'd0, 3'd0, 32'h0000_1000);
        check(exc_base == 32'h0000_1000, "R12", "base after write", exc_base, 32'h0000_1000);
        access(1'b0, 1'b1, 1'b1, 4'd12, 3'd0, 4'd0, 3'd0, 32'h0);
        check_rsp(2'd1, 32'h0000_1000, "R12");

        // R13 variant without security support
        access(1'b0, 1'b1, 1'b1, 4'd12, 3'd0, 4'd0, 3'd0, 32'h0);
        check(f_valid && f_undef && !f_unpred, "R13", "undef when absent",
              {29'd0, f_valid, f_undef, f_unpred}, 32'd6);
        access(1'b0, 1'b1, 1'b1, 4'd12, 3'd0, 4'd3, 3'd5, 32'h0);
        check(f_valid && f_undef && !f_unpred, "R13", "undef for any encoding",
              {29'd0, f_valid, f_undef, f_unpred}, 32'd6);
        idle();

        // R5 reset again clears only the secure copy
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 1'b1, 1'b1, 4'd12, 3'd0, 4'd0, 3'd0, 32'h0);
        check_rsp(2'd1, 32'h0, "R5");
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule